// File: doc/BRIEF.md
# Wavefront Initial Register Sequencer

The sequencer accepts one dispatch descriptor together with a 32-bit property word of enable bits and a small set of per-wave enables. It then emits, one per clock, the ordered list of 32-bit scalar register writes that prime a wavefront before it runs. Each write is an index/data pair. Enabled fields receive dense register numbers starting at zero, and a disabled field takes no number.

Dispatch-wide user fields come first. Their total is capped at a parameterised limit of 16 registers: a field that crosses the limit is cut, and later user fields are dropped. Per-wave system fields follow directly after the last user register. Before emission starts, three iterative dividers compute the work-group count of each grid dimension by ceiling division. The block also packs the work-group info word, reports the saturated user register count, and drives a vector work-item ID mask.

The intended use is between a dispatch front end and a wave launcher. The front end presents a descriptor when `disp_ready` is high. The launcher consumes writes with `wr_ready` and sees `done` once the list is complete.

Top module: `wis_seq_top`

## Requirements
- R1: `disp_ready` is high only when the block is idle (no division, no emission, no done cycle). A `disp_valid` raised while busy is ignored and leaves the write stream unchanged.
- R2: The first write of a dispatch has index 0, and every later write has the previous index plus one. User field enables are `prop_word` bits 0..9 in emission order: private segment buffer (4 regs), dispatch pointer (2), queue pointer (2), kernarg pointer (2), dispatch ID (2), flat scratch init (2), private segment size (1), then work-group counts X, Y, Z (1 each).
- R3: A 128-bit field is emitted as its 32-bit words from least significant upward. A 64-bit field is emitted low half first. Flat scratch init is the scratch offset followed by the rounded private size.
- R4: At most 16 user registers are written. A field crossing the limit is cut and later user fields are dropped. `user_cnt` equals the requested user register total, saturated at 16.
- R5: The work-group count of each dimension equals ceil(grid size / work-group size) for any 32-bit grid size and non-zero 16-bit work-group size.
- R6: System writes follow the last user write in this order: work-group ID X (always), Y (`sys_en[0]`), Z (`sys_en[1]`), info (`sys_en[2]`), wave byte offset (`sys_en[3]`). Enabling Z also emits Y.
- R7: The info word is {`first_wave` at bit 31, zeros in bits 30..17, `append_term` in bits 16..6, `waves_in_group` in bits 5..0}.
- R8: `vid_mask` is 001 for `vid_req`=0, 011 for 1, and 111 for 2 or 3. Bit 0 is always set.
- R9: The private size value written (private segment size field and second flat scratch word) is `priv_bytes` rounded up to a multiple of 4.
- R10: `prop_word` bits 10..31 have no effect on the write stream or on `user_cnt`.
- R11: While `wr_valid` is high and `wr_ready` low, `wr_valid`, `wr_idx` and `wr_data` hold.
- R12: `done` is high for exactly one cycle, in the cycle after the last write is accepted, and `wr_valid` is low then.
- R13: A zero work-group size in any dimension sets `err` for that dispatch, and that dimension's count is written as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Descriptor offered |
| disp_ready | output | 1 | Idle, descriptor accepted this cycle if valid |
| prop_word | input | 32 | Property word, user field enables in bits 0..9 |
| sys_en | input | 4 | System enables: Y ID, Z ID, info, wave offset |
| vid_req | input | 2 | Vector work-item ID selection request |
| psb_desc | input | 128 | Private segment buffer descriptor |
| dispatch_ptr | input | 64 | Dispatch packet address |
| queue_ptr | input | 64 | Queue object address |
| kernarg_ptr | input | 64 | Kernel argument segment address |
| dispatch_id | input | 64 | Dispatch identifier |
| scratch_off | input | 32 | Scratch byte offset of the dispatch |
| priv_bytes | input | 32 | Per-item private byte size before rounding |
| grid_size | input | 96 | Grid size, X in bits 31..0, Y 63..32, Z 95..64 |
| wg_size | input | 48 | Work-group size, X in bits 15..0, Y 31..16, Z 47..32 |
| wg_id | input | 96 | Work-group ID of the wave, X low, Z high |
| first_wave | input | 1 | First wave of the group flag |
| append_term | input | 11 | Ordered append term |
| waves_in_group | input | 6 | Waves per work-group |
| wave_byte_off | input | 32 | Per-wave private byte offset |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register write taken |
| wr_idx | output | 5 | Scalar register number |
| wr_data | output | 32 | Value to write |
| done | output | 1 | One-cycle pulse after the final write |
| err | output | 1 | A work-group size was zero |
| user_cnt | output | 5 | Saturated user register count |
| vid_mask | output | 3 | Vector ID dimensions initialised (X,Y,Z = bits 0,1,2) |

## Verification
The assertions assume a well-behaved consumer and producer. `wr_ready` may stall for any number of cycles but is only sampled while `wr_valid` is high. Descriptor inputs matter only in the cycle `disp_valid` meets `disp_ready`. `priv_bytes` is assumed not to wrap within 3 of its maximum. The directed stimulus respects these limits: it holds descriptor values stable across the accepting edge, and keeps private sizes small. It also raises `disp_valid` mid-stream only to observe that nothing changes. Stalls are a fixed repeating pattern, so the hold rule is exercised at several points of a stream.

// File: rtl/wis_pkg.sv
package wis_pkg;

  localparam int REG_W      = 32;
  localparam int NUM_USER   = 10;
  localparam int NUM_SYS    = 5;
  localparam int NUM_FIELDS = NUM_USER + NUM_SYS;
  localparam int FLD_W      = $clog2(NUM_FIELDS + 1);
  localparam int SYS_BASE   = NUM_USER;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_EMIT = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  // Latched descriptor, everything the word mux can select from
  typedef struct packed {
    logic [4*REG_W-1:0]      psb;
    logic [2*REG_W-1:0]      dptr;
    logic [2*REG_W-1:0]      qptr;
    logic [2*REG_W-1:0]      kptr;
    logic [2*REG_W-1:0]      did;
    logic [REG_W-1:0]        scr_off;
    logic [REG_W-1:0]        priv_rnd;
    logic [2:0][REG_W-1:0]   wg_cnt;
    logic [2:0][REG_W-1:0]   wg_id;
    logic [REG_W-1:0]        info;
    logic [REG_W-1:0]        wave_off;
  } desc_t;

  // Registers occupied by each field, user fields 0..9, system 10..14
  function automatic logic [2:0] field_len(input logic [FLD_W-1:0] f);
    case (f)
      FLD_W'(0):                                 return 3'd4;
      FLD_W'(1), FLD_W'(2), FLD_W'(3),
      FLD_W'(4), FLD_W'(5):                      return 3'd2;
      default:                                   return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/wis_ceil_div.sv
module wis_ceil_div #(
  parameter int NUM_W = 33,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);

  localparam int CNT_W  = $clog2(NUM_W + 1);
  localparam int PROD_W = NUM_W + DEN_W;

  logic [DEN_W:0]   rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [NUM_W-1:0] num_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;
  logic             zero_q;

  logic [DEN_W:0]   rem_sh;
  logic [DEN_W:0]   rem_sub;
  logic             take;

  // One restoring step per cycle, quotient bits shift in from the right
  always_comb begin
    rem_sh  = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
    take    = rem_sh >= {1'b0, den_q};
    rem_sub = rem_sh - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      num_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q  <= '0;
        quo_q  <= num;
        num_q  <= num;
        den_q  <= den;
        cnt_q  <= CNT_W'(NUM_W);
        busy_q <= 1'b1;
        zero_q <= (den == '0);
      end else if (busy_q) begin
        rem_q <= take ? rem_sub : rem_sh;
        quo_q <= {quo_q[NUM_W-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = zero_q ? '0 : quo_q;

  // Quotient is exact floor: q*d <= n < (q+1)*d
  logic [PROD_W-1:0] chk_prod;
  logic [PROD_W-1:0] chk_num;
  assign chk_prod = PROD_W'(quo_q) * PROD_W'(den_q);
  assign chk_num  = PROD_W'(num_q);

  p_floor_exact_r5: assert property (@(posedge clk) disable iff (rst)
    (done_q && !zero_q) |-> (chk_prod <= chk_num) &&
                            ((chk_num - chk_prod) < PROD_W'(den_q)));

endmodule

// File: rtl/wis_next_field.sv
module wis_next_field
  import wis_pkg::*;
(
  input  logic [NUM_FIELDS-1:0] fen,
  input  logic [FLD_W-1:0]      from,
  output logic                  found,
  output logic [FLD_W-1:0]      fld
);

  // Lowest enabled field at or above 'from'
  always_comb begin
    found = 1'b0;
    fld   = '0;
    for (int i = NUM_FIELDS - 1; i >= 0; i--) begin
      if (fen[i] && (FLD_W'(i) >= from)) begin
        found = 1'b1;
        fld   = FLD_W'(i);
      end
    end
  end

endmodule

// File: rtl/wis_word_mux.sv
module wis_word_mux
  import wis_pkg::*;
(
  input  desc_t             desc,
  input  logic [FLD_W-1:0]  fld,
  input  logic [1:0]        wrd,
  output logic [REG_W-1:0]  data
);

  function automatic logic [REG_W-1:0] half(input logic [2*REG_W-1:0] v,
                                            input logic            hi);
    return hi ? v[2*REG_W-1:REG_W] : v[REG_W-1:0];
  endfunction

  always_comb begin
    case (fld)
      FLD_W'(0):  data = desc.psb[{wrd, 5'b0} +: REG_W];
      FLD_W'(1):  data = half(desc.dptr, wrd[0]);
      FLD_W'(2):  data = half(desc.qptr, wrd[0]);
      FLD_W'(3):  data = half(desc.kptr, wrd[0]);
      FLD_W'(4):  data = half(desc.did,  wrd[0]);
      FLD_W'(5):  data = wrd[0] ? desc.priv_rnd : desc.scr_off;
      FLD_W'(6):  data = desc.priv_rnd;
      FLD_W'(7):  data = desc.wg_cnt[0];
      FLD_W'(8):  data = desc.wg_cnt[1];
      FLD_W'(9):  data = desc.wg_cnt[2];
      FLD_W'(10): data = desc.wg_id[0];
      FLD_W'(11): data = desc.wg_id[1];
      FLD_W'(12): data = desc.wg_id[2];
      FLD_W'(13): data = desc.info;
      FLD_W'(14): data = desc.wave_off;
      default:    data = '0;
    endcase
  end

endmodule

// File: rtl/wis_seq_top.sv
module wis_seq_top
  import wis_pkg::*;
#(
  parameter int  GRID_W   = 32,
  parameter int  WG_W     = 16,
  parameter int  USER_MAX = 16,
  localparam int IDX_W    = $clog2(USER_MAX + NUM_SYS + 1),
  localparam int UCNT_W   = $clog2(USER_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 disp_valid,
  output logic                 disp_ready,
  input  logic [31:0]          prop_word,
  input  logic [3:0]           sys_en,
  input  logic [1:0]           vid_req,
  input  logic [4*REG_W-1:0]   psb_desc,
  input  logic [2*REG_W-1:0]   dispatch_ptr,
  input  logic [2*REG_W-1:0]   queue_ptr,
  input  logic [2*REG_W-1:0]   kernarg_ptr,
  input  logic [2*REG_W-1:0]   dispatch_id,
  input  logic [REG_W-1:0]     scratch_off,
  input  logic [REG_W-1:0]     priv_bytes,
  input  logic [3*GRID_W-1:0]  grid_size,
  input  logic [3*WG_W-1:0]    wg_size,
  input  logic [3*REG_W-1:0]   wg_id,
  input  logic                 first_wave,
  input  logic [10:0]          append_term,
  input  logic [5:0]           waves_in_group,
  input  logic [REG_W-1:0]     wave_byte_off,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [REG_W-1:0]     wr_data,
  output logic                 done,
  output logic                 err,
  output logic [UCNT_W-1:0]    user_cnt,
  output logic [2:0]           vid_mask
);

  localparam int NUM_W = GRID_W + 1;

  seq_state_t              st_q;
  desc_t                   desc_q;
  desc_t                   desc_mux;
  logic [NUM_FIELDS-1:0]   fen_q;
  logic [FLD_W-1:0]        fld_q;
  logic [1:0]              wrd_q;
  logic [IDX_W-1:0]        idx_q;

  logic                    accept;
  logic                    prop_unused;

  assign disp_ready  = (st_q == ST_IDLE);
  assign accept      = disp_valid && disp_ready;
  assign prop_unused = ^prop_word[31:NUM_USER];

  // ---------------- descriptor preparation at acceptance ----------------
  logic [REG_W-1:0]        priv_rnd_in;
  logic [REG_W-1:0]        info_in;
  logic [NUM_FIELDS-1:0]   fen_in;
  logic [UCNT_W-1:0]       ucnt_in;
  logic [2:0]              vmask_in;
  logic                    zero_in;

  always_comb begin
    int sum;
    priv_rnd_in = (priv_bytes + REG_W'(3)) & ~REG_W'(3);
    info_in     = {first_wave, 14'b0, append_term, waves_in_group};
    fen_in[NUM_USER-1:0] = prop_word[NUM_USER-1:0];
    fen_in[SYS_BASE]     = 1'b1;
    fen_in[SYS_BASE+1]   = sys_en[0] | sys_en[1];
    fen_in[SYS_BASE+2]   = sys_en[1];
    fen_in[SYS_BASE+3]   = sys_en[2];
    fen_in[SYS_BASE+4]   = sys_en[3];
    sum = 0;
    for (int i = 0; i < NUM_USER; i++) begin
      if (prop_word[i]) sum += int'(field_len(FLD_W'(i)));
    end
    ucnt_in = (sum > USER_MAX) ? UCNT_W'(USER_MAX) : UCNT_W'(sum);
    case (vid_req)
      2'd0:    vmask_in = 3'b001;
      2'd1:    vmask_in = 3'b011;
      default: vmask_in = 3'b111;
    endcase
    zero_in = 1'b0;
    for (int d = 0; d < 3; d++) begin
      if (wg_size[d*WG_W +: WG_W] == '0) zero_in = 1'b1;
    end
  end

  // ---------------- work-group count dividers ----------------
  logic [2:0][NUM_W-1:0] div_num;
  logic [2:0][NUM_W-1:0] div_quo;
  logic [2:0]            div_done;

  for (genvar d = 0; d < 3; d++) begin : g_div
    assign div_num[d] = NUM_W'(grid_size[d*GRID_W +: GRID_W]) +
                        NUM_W'(wg_size[d*WG_W +: WG_W]) - NUM_W'(1);
    wis_ceil_div #(
      .NUM_W (NUM_W),
      .DEN_W (WG_W)
    ) u_div (
      .clk   (clk),
      .rst   (rst),
      .start (accept),
      .num   (div_num[d]),
      .den   (wg_size[d*WG_W +: WG_W]),
      .done  (div_done[d]),
      .quo   (div_quo[d])
    );
  end

  logic div_unused;
  assign div_unused = ^div_done[2:1] ^ div_quo[0][GRID_W] ^
                      div_quo[1][GRID_W] ^ div_quo[2][GRID_W];

  // Counts bypass the register in the cycle they become available
  always_comb begin
    desc_mux = desc_q;
    if (st_q == ST_DIV) begin
      for (int d = 0; d < 3; d++) desc_mux.wg_cnt[d] = REG_W'(div_quo[d]);
    end
  end

  // ---------------- next write pointer ----------------
  logic [IDX_W-1:0] idx_n;
  logic             user_full;
  logic             stay;
  logic [FLD_W-1:0] search_from;
  logic             nf_found;
  logic [FLD_W-1:0] nf_fld;
  logic [FLD_W-1:0] nxt_fld;
  logic [1:0]       nxt_wrd;
  logic [REG_W-1:0] nxt_data;

  always_comb begin
    idx_n     = idx_q + 1'b1;
    user_full = (idx_n >= IDX_W'(USER_MAX));
    stay      = (({1'b0, wrd_q} + 3'd1) < field_len(fld_q)) &&
                !((fld_q < FLD_W'(SYS_BASE)) && user_full);
    if (st_q == ST_DIV) begin
      search_from = '0;
    end else begin
      search_from = fld_q + 1'b1;
      if ((fld_q < FLD_W'(SYS_BASE)) && user_full &&
          (search_from < FLD_W'(SYS_BASE))) begin
        search_from = FLD_W'(SYS_BASE);
      end
    end
    if ((st_q != ST_DIV) && stay) begin
      nxt_fld = fld_q;
      nxt_wrd = wrd_q + 1'b1;
    end else begin
      nxt_fld = nf_fld;
      nxt_wrd = 2'd0;
    end
  end

  wis_next_field u_next (
    .fen   (fen_q),
    .from  (search_from),
    .found (nf_found),
    .fld   (nf_fld)
  );

  wis_word_mux u_mux (
    .desc  (desc_mux),
    .fld   (nxt_fld),
    .wrd   (nxt_wrd),
    .data  (nxt_data)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      desc_q   <= '0;
      fen_q    <= '0;
      fld_q    <= '0;
      wrd_q    <= '0;
      idx_q    <= '0;
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      user_cnt <= '0;
      vid_mask <= 3'b001;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            desc_q.psb      <= psb_desc;
            desc_q.dptr     <= dispatch_ptr;
            desc_q.qptr     <= queue_ptr;
            desc_q.kptr     <= kernarg_ptr;
            desc_q.did      <= dispatch_id;
            desc_q.scr_off  <= scratch_off;
            desc_q.priv_rnd <= priv_rnd_in;
            desc_q.wg_id    <= wg_id;
            desc_q.info     <= info_in;
            desc_q.wave_off <= wave_byte_off;
            fen_q           <= fen_in;
            user_cnt        <= ucnt_in;
            vid_mask        <= vmask_in;
            err             <= zero_in;
            st_q            <= ST_DIV;
          end
        end
        ST_DIV: begin
          if (div_done[0]) begin
            for (int d = 0; d < 3; d++) desc_q.wg_cnt[d] <= REG_W'(div_quo[d]);
            fld_q    <= nxt_fld;
            wrd_q    <= nxt_wrd;
            idx_q    <= '0;
            wr_valid <= 1'b1;
            wr_idx   <= '0;
            wr_data  <= nxt_data;
            st_q     <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (wr_ready) begin
            if (stay || nf_found) begin
              fld_q   <= nxt_fld;
              wrd_q   <= nxt_wrd;
              idx_q   <= idx_n;
              wr_idx  <= idx_n;
              wr_data <= nxt_data;
            end else begin
              wr_valid <= 1'b0;
              done     <= 1'b1;
              st_q     <= ST_DONE;
            end
          end
        end
        default: begin
          st_q <= ST_IDLE;
        end
      endcase
    end
  end

  // ---------------- properties ----------------
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (rst)
    disp_ready |-> !wr_valid && !done);

  p_first_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> (wr_idx == '0));

  p_dense_idx_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_valid || (wr_idx == $past(wr_idx) + 1'b1));

  p_user_sat_r4: assert property (@(posedge clk) disable iff (rst)
    user_cnt <= UCNT_W'(USER_MAX));

  p_sys_tail_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && (fld_q >= FLD_W'(SYS_BASE))) |-> (wr_idx <= IDX_W'(user_cnt) + IDX_W'(NUM_SYS - 1)));

  p_vid_contig_r8: assert property (@(posedge clk) disable iff (rst)
    vid_mask[0] && (!vid_mask[2] || vid_mask[1]));

  p_hold_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_idx) && $stable(wr_data));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_last_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_valid && $past(wr_valid && wr_ready));

endmodule

// File: tb/wis_seq_top_tb_top.sv
module wis_seq_top_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         disp_valid = 1'b0;
  logic         disp_ready;
  logic [31:0]  prop_word = '0;
  logic [3:0]   sys_en = '0;
  logic [1:0]   vid_req = '0;
  logic [127:0] psb_desc = '0;
  logic [63:0]  dispatch_ptr = '0, queue_ptr = '0, kernarg_ptr = '0, dispatch_id = '0;
  logic [31:0]  scratch_off = '0, priv_bytes = '0;
  logic [95:0]  grid_size = '0;
  logic [47:0]  wg_size = '0;
  logic [95:0]  wg_id = '0;
  logic         first_wave = 1'b0;
  logic [10:0]  append_term = '0;
  logic [5:0]   waves_in_group = '0;
  logic [31:0]  wave_byte_off = '0;
  logic         wr_valid;
  logic         wr_ready = 1'b1;
  logic [4:0]   wr_idx;
  logic [31:0]  wr_data;
  logic         done, err;
  logic [4:0]   user_cnt;
  logic [2:0]   vid_mask;

  wis_seq_top dut_i (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .prop_word(prop_word), .sys_en(sys_en), .vid_req(vid_req), .psb_desc(psb_desc),
    .dispatch_ptr(dispatch_ptr), .queue_ptr(queue_ptr), .kernarg_ptr(kernarg_ptr),
    .dispatch_id(dispatch_id), .scratch_off(scratch_off), .priv_bytes(priv_bytes),
    .grid_size(grid_size), .wg_size(wg_size), .wg_id(wg_id), .first_wave(first_wave),
    .append_term(append_term), .waves_in_group(waves_in_group),
    .wave_byte_off(wave_byte_off), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_idx(wr_idx), .wr_data(wr_data), .done(done), .err(err),
    .user_cnt(user_cnt), .vid_mask(vid_mask));

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model from the requirements ----------------
  logic [31:0] exp_d [0:31];
  int          exp_n;
  logic [4:0]  exp_ucnt;
  logic [2:0]  exp_vmask;
  logic        exp_err;

  function automatic logic [31:0] ceil_cnt(input logic [31:0] g, input logic [15:0] w);
    logic [63:0] t;
    if (w == 16'd0) return 32'd0;
    t = ({32'd0, g} + {48'd0, w} - 64'd1) / {48'd0, w};
    return t[31:0];
  endfunction

  function automatic logic [31:0] ref_word(input int f, input int w);
    logic [31:0] rnd;
    rnd = (priv_bytes + 32'd3) & 32'hFFFF_FFFC;
    case (f)
      0: return psb_desc[32*w +: 32];
      1: return dispatch_ptr[32*w +: 32];
      2: return queue_ptr[32*w +: 32];
      3: return kernarg_ptr[32*w +: 32];
      4: return dispatch_id[32*w +: 32];
      5: return (w == 0) ? scratch_off : rnd;
      6: return rnd;
      default: return ceil_cnt(grid_size[32*(f-7) +: 32], wg_size[16*(f-7) +: 16]);
    endcase
  endfunction

  task automatic build_expected();
    int lens [0:9];
    int req;
    lens = '{4, 2, 2, 2, 2, 2, 1, 1, 1, 1};
    exp_n = 0;
    req = 0;
    for (int f = 0; f < 10; f++) begin
      if (prop_word[f]) begin
        for (int w = 0; w < lens[f]; w++) begin
          req++;
          if (exp_n < 16) begin exp_d[exp_n] = ref_word(f, w); exp_n++; end
        end
      end
    end
    exp_ucnt = (req > 16) ? 5'd16 : 5'(req);
    exp_d[exp_n] = wg_id[31:0]; exp_n++;
    if (sys_en[0] || sys_en[1]) begin exp_d[exp_n] = wg_id[63:32]; exp_n++; end
    if (sys_en[1]) begin exp_d[exp_n] = wg_id[95:64]; exp_n++; end
    if (sys_en[2]) begin
      exp_d[exp_n] = {first_wave, 14'd0, append_term, waves_in_group}; exp_n++;
    end
    if (sys_en[3]) begin exp_d[exp_n] = wave_byte_off; exp_n++; end
    exp_vmask = (vid_req == 2'd0) ? 3'b001 : (vid_req == 2'd1) ? 3'b011 : 3'b111;
    exp_err = (wg_size[15:0] == 0) || (wg_size[31:16] == 0) || (wg_size[47:32] == 0);
  endtask

  // ---------------- dispatch and collect ----------------
  // mode 0: always ready, mode 1: stall pattern, mode 2: inject busy dispatch
  task automatic run_dispatch(input string req, input int mode);
    logic [31:0] got_d [0:63];
    logic [4:0]  got_i [0:63];
    int n, cyc, inj;
    bit seen_done;
    build_expected();
    wr_ready = 1'b1;
    @(negedge clk);
    while (!disp_ready) @(negedge clk);
    disp_valid = 1'b1;
    @(negedge clk);
    disp_valid = 1'b0;
    n = 0; cyc = 0; inj = 0; seen_done = 0;
    while (!seen_done && cyc < 5000) begin
      if (wr_valid && wr_ready && n < 64) begin
        got_d[n] = wr_data; got_i[n] = wr_idx; n++;
      end
      if (done) seen_done = 1;
      wr_ready = (mode == 1) ? ((cyc % 3) != 1) : 1'b1;
      if (mode == 2) begin
        if (n >= 2 && inj < 4) begin
          chk("R1", "busy disp_ready", 64'(disp_ready), 64'd0);
          disp_valid = 1'b1;
          prop_word = 32'h0000_03FF;
          grid_size = {3{32'd77}};
          inj++;
        end else begin
          disp_valid = 1'b0;
        end
      end
      @(negedge clk);
      cyc++;
    end
    disp_valid = 1'b0;
    chk(req, "done seen", 64'(seen_done), 64'd1);
    chk("R12", "done one cycle", 64'(done), 64'd0);
    chk("R12", "valid low after done", 64'(wr_valid), 64'd0);
    chk(req, "write count", 64'(n), 64'(exp_n));
    for (int k = 0; k < n && k < exp_n; k++) begin
      chk("R2", $sformatf("index %0d", k), 64'(got_i[k]), 64'(k));
      chk(req, $sformatf("data %0d", k), 64'(got_d[k]), 64'(exp_d[k]));
    end
    chk("R4", "user_cnt", 64'(user_cnt), 64'(exp_ucnt));
    chk("R8", "vid_mask", 64'(vid_mask), 64'(exp_vmask));
    chk("R13", "err", 64'(err), 64'(exp_err));
  endtask

  task automatic set_base();
    psb_desc       = 128'h4444_0004_3333_0003_2222_0002_1111_0001;
    dispatch_ptr   = 64'hD1D1_0000_0000_D0D0;
    queue_ptr      = 64'hABAB_1111_CDCD_2222;
    kernarg_ptr    = 64'h0000_7F00_1234_5000;
    dispatch_id    = 64'h0000_0001_0000_002A;
    scratch_off    = 32'h0001_0000;
    priv_bytes     = 32'd64;
    grid_size      = {32'd256, 32'd100, 32'd1000};
    wg_size        = {16'd64, 16'd16, 16'd256};
    wg_id          = {32'd3, 32'd2, 32'd1};
    first_wave     = 1'b1;
    append_term    = 11'h5A5;
    waves_in_group = 6'd33;
    wave_byte_off  = 32'h0000_4400;
    vid_req        = 2'd0;
    sys_en         = 4'b0000;
    prop_word      = '0;
  endtask

  task automatic t_reset();
    chk("R1", "reset disp_ready", 64'(disp_ready), 64'd1);
    chk("R12", "reset wr_valid", 64'(wr_valid), 64'd0);
    chk("R12", "reset done", 64'(done), 64'd0);
    chk("R13", "reset err", 64'(err), 64'd0);
    chk("R8", "reset vid_mask", 64'(vid_mask), 64'b001);
  endtask

  task automatic t_minimal();   // R6: only work-group ID X
    set_base();
    run_dispatch("R6", 0);
  endtask

  task automatic t_typical();   // R2 R3 R5 R6 R7 R11
    set_base();
    prop_word = 32'h0000_0199;   // psb, kernarg, dispatch id, count X, count Y
    sys_en    = 4'b0101;         // Y id, info
    vid_req   = 2'd1;
    run_dispatch("R3", 1);
  endtask

  task automatic t_truncate();  // R4, R6 (Z forces Y)
    set_base();
    prop_word = 32'h0000_03FF;
    sys_en    = 4'b0010;
    vid_req   = 2'd2;
    run_dispatch("R4", 1);
  endtask

  task automatic t_round_zero(); // R9 R10 R13
    set_base();
    priv_bytes = 32'd13;
    wg_size    = {16'd64, 16'd0, 16'd256};
    prop_word  = 32'h8010_FD60;  // flat scratch, priv size, count Y + junk above bit 9
    sys_en     = 4'b1000;
    vid_req    = 2'd3;
    run_dispatch("R9", 0);
  endtask

  task automatic t_division();  // R5
    set_base();
    grid_size = {32'd1001, 32'd1000, 32'hFFFF_FFFF};
    wg_size   = {16'd10, 16'd10, 16'd1};
    prop_word = 32'h0000_0380;
    vid_req   = 2'd2;
    run_dispatch("R5", 1);
    grid_size = {32'd1, 32'd65535, 32'd65536};
    wg_size   = {16'd65535, 16'd65535, 16'd65535};
    run_dispatch("R5", 0);
  endtask

  task automatic t_busy();      // R1
    set_base();
    prop_word = 32'h0000_0007;
    sys_en    = 4'b1111;
    run_dispatch("R1", 2);
    repeat (3) begin
      @(negedge clk);
      chk("R1", "no stray dispatch", 64'(wr_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_minimal();
    t_typical();
    t_truncate();
    t_round_zero();
    t_division();
    t_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule